// File: doc/BRIEF.md
# Paired-Byte Configuration Register Decoder

This block accepts configuration traffic as a plain byte stream, one byte for each cycle in which `in_valid` is high. The bytes come in pairs. The first byte of a pair names a register and must have bit 7 set. The second byte is the value written to that register.

The decoder keeps the following registers and drives each one straight out to its consumers:

- two input-threshold codes, one for each channel group;
- a probe-mode byte whose bits select differential pairing of two channel pairs;
- three identity bytes;
- a stream register, which takes a run of values written one after another.

Every accepted write produces a one-cycle pulse that carries the register address. An address byte that is malformed produces an error pulse instead.

Typical use is between a host link and the front-end analog controls. Because every write is announced, downstream logic can sequence on the pulse, for example to clock each stream value into an external device.

Top module: `cfg_byte_decoder`

## Requirements
- R1: While `rst` is high and after its release, both threshold codes read 0x7F, the probe mode reads 0x40, the identity bytes and stream byte read 0x00, and `wr_pulse` and `err_pulse` are low.
- R2: In the address phase, a valid byte with bit 7 set is taken as the address. The next valid byte is taken as the data byte, whatever its value. Cycles with `in_valid` low are ignored in either phase.
- R3: Address 0x89 writes the full data byte to the group A threshold, `thr_codes[7:0]`. Address 0x8A writes it to the group B threshold, `thr_codes[15:8]`.
- R4: Address 0x88 writes the probe mode. `diff_56` follows bit 4 of the mode and `diff_78` follows bit 3. So 0x40 means neither pair is differential, 0x50 makes pair 5/6 differential, 0x48 makes pair 7/8 differential, and 0x58 makes both differential.
- R5: Addresses 0x8C, 0x8E and 0x8F write identity bytes 0, 1 and 2. These are `dev_ids[7:0]`, `[15:8]` and `[23:16]`. Bit 7 of each is always stored as 0.
- R6: Address 0x8D writes `stream_byte`. Each pair to this address updates it and gives its own write pulse, even when the same address is repeated.
- R7: After the edge that accepts a data byte for a mapped address, the targeted output shows the new value. In that same cycle, `wr_pulse` is high for exactly one cycle and `wr_addr` holds the address. A register changes only in a cycle in which `wr_pulse` is high.
- R8: In the address phase, a valid byte with bit 7 clear raises `err_pulse` for one cycle after the edge and writes nothing. The parser stays in the address phase.
- R9: An address with bit 7 set that matches no register still consumes the following data byte. It changes no register and raises neither pulse.
- R10: Pairs may arrive with no gap, one byte per cycle. Every pair then gives its own update and pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe |
| in_byte | input | 8 | Incoming command byte |
| thr_codes | output | THR_N*8 | Threshold codes, group A in the low byte |
| probe_mode | output | 8 | Probe-mode register |
| diff_56 | output | 1 | Channel pair 5/6 differential |
| diff_78 | output | 1 | Channel pair 7/8 differential |
| dev_ids | output | ID_N*8 | Identity bytes, byte 0 lowest |
| stream_byte | output | 8 | Last value written to the stream address |
| wr_pulse | output | 1 | One-cycle write indication |
| wr_addr | output | 8 | Address of the write being indicated |
| err_pulse | output | 1 | One-cycle malformed-address indication |

## Verification
The bench builds the decoder with its default parameters: two threshold groups, three identity bytes and the default address map. With these values every mapped address, one unmapped address and both parser phases can be reached using short directed sequences. The default map also puts the identity addresses on a non-contiguous spacing, so the bench exercises lookup by address rather than by offset. The bench covers these cases:

- a malformed address in the middle of a stream;
- idle gaps inside a pair;
- data bytes that have bit 7 clear or bit 7 set;
- gapless back-to-back pairs;
- repeated writes to the stream address.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic {
    PH_ADDR = 1'b0,
    PH_DATA = 1'b1
  } phase_t;

  typedef struct packed {
    logic              en;
    logic [BYTE_W-1:0] addr;
    logic [BYTE_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/cfgdec_parser.sv
module cfgdec_parser
  import cfgdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output wr_req_t           req,
  output logic              bad_addr
);
  localparam int MSB = BYTE_W - 1;

  phase_t            phase_q;
  logic [BYTE_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_ADDR;
      addr_q  <= '0;
    end else if (in_valid) begin
      case (phase_q)
        PH_ADDR: begin
          if (in_byte[MSB]) begin
            addr_q  <= in_byte;
            phase_q <= PH_DATA;
          end
        end
        default: phase_q <= PH_ADDR;
      endcase
    end
  end

  always_comb begin
    req.en   = in_valid && (phase_q == PH_DATA);
    req.addr = addr_q;
    req.data = in_byte;
    bad_addr = in_valid && (phase_q == PH_ADDR) && !in_byte[MSB];
  end
endmodule

// File: rtl/cfgdec_regslot.sv
module cfgdec_regslot
  import cfgdec_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ADDR    = 8'h80,
  parameter logic [BYTE_W-1:0] RST_VAL = '0,
  parameter bit                CLR_MSB = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  wr_req_t           req,
  output logic              hit,
  output logic [BYTE_W-1:0] q
);
  logic [BYTE_W-1:0] next_val;

  always_comb begin
    hit      = req.en && (req.addr == ADDR);
    next_val = req.data;
    if (CLR_MSB) next_val[BYTE_W-1] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)      q <= RST_VAL;
    else if (hit) q <= next_val;
  end
endmodule

// File: rtl/cfg_byte_decoder.sv
module cfg_byte_decoder
  import cfgdec_pkg::*;
#(
  parameter int                            THR_N       = 2,
  parameter logic [THR_N-1:0][BYTE_W-1:0]  THR_ADDRS   = {8'h8A, 8'h89},
  parameter logic [BYTE_W-1:0]             THR_RST     = 8'h7F,
  parameter logic [BYTE_W-1:0]             MODE_ADDR   = 8'h88,
  parameter logic [BYTE_W-1:0]             MODE_RST    = 8'h40,
  parameter int                            DIFF56_BIT  = 4,
  parameter int                            DIFF78_BIT  = 3,
  parameter int                            ID_N        = 3,
  parameter logic [ID_N-1:0][BYTE_W-1:0]   ID_ADDRS    = {8'h8F, 8'h8E, 8'h8C},
  parameter logic [BYTE_W-1:0]             STREAM_ADDR = 8'h8D
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [BYTE_W-1:0]       in_byte,
  output logic [THR_N*BYTE_W-1:0] thr_codes,
  output logic [BYTE_W-1:0]       probe_mode,
  output logic                    diff_56,
  output logic                    diff_78,
  output logic [ID_N*BYTE_W-1:0]  dev_ids,
  output logic [BYTE_W-1:0]       stream_byte,
  output logic                    wr_pulse,
  output logic [BYTE_W-1:0]       wr_addr,
  output logic                    err_pulse
);
  localparam int SLOTS    = THR_N + ID_N + 2;
  localparam int MODE_IX  = THR_N + ID_N;
  localparam int STRM_IX  = THR_N + ID_N + 1;

  wr_req_t          req;
  logic             bad_addr;
  logic [SLOTS-1:0] hits;

  cfgdec_parser u_parser (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .req      (req),
    .bad_addr (bad_addr)
  );

  for (genvar g = 0; g < THR_N; g++) begin : g_thr
    cfgdec_regslot #(.ADDR(THR_ADDRS[g]), .RST_VAL(THR_RST), .CLR_MSB(1'b0)) u_slot (
      .clk (clk),
      .rst (rst),
      .req (req),
      .hit (hits[g]),
      .q   (thr_codes[g*BYTE_W +: BYTE_W])
    );
  end

  for (genvar g = 0; g < ID_N; g++) begin : g_id
    cfgdec_regslot #(.ADDR(ID_ADDRS[g]), .RST_VAL('0), .CLR_MSB(1'b1)) u_slot (
      .clk (clk),
      .rst (rst),
      .req (req),
      .hit (hits[THR_N+g]),
      .q   (dev_ids[g*BYTE_W +: BYTE_W])
    );
  end

  cfgdec_regslot #(.ADDR(MODE_ADDR), .RST_VAL(MODE_RST), .CLR_MSB(1'b0)) u_mode (
    .clk (clk),
    .rst (rst),
    .req (req),
    .hit (hits[MODE_IX]),
    .q   (probe_mode)
  );

  cfgdec_regslot #(.ADDR(STREAM_ADDR), .RST_VAL('0), .CLR_MSB(1'b0)) u_stream (
    .clk (clk),
    .rst (rst),
    .req (req),
    .hit (hits[STRM_IX]),
    .q   (stream_byte)
  );

  assign diff_56 = probe_mode[DIFF56_BIT];
  assign diff_78 = probe_mode[DIFF78_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_pulse  <= 1'b0;
      wr_addr   <= '0;
      err_pulse <= 1'b0;
    end else begin
      wr_pulse  <= |hits;
      err_pulse <= bad_addr;
      if (|hits) wr_addr <= req.addr;
    end
  end
endmodule

// File: rtl/cfg_byte_decoder_chk.sv
module cfg_byte_decoder_chk #(
  parameter int THR_N = 2,
  parameter int ID_N  = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic [7:0]            in_byte,
  input logic [THR_N*8-1:0]    thr_codes,
  input logic [7:0]            probe_mode,
  input logic [ID_N*8-1:0]     dev_ids,
  input logic [7:0]            stream_byte,
  input logic                  wr_pulse,
  input logic [7:0]            wr_addr,
  input logic                  err_pulse
);
  logic            started = 1'b0;
  logic [ID_N-1:0] id_msbs;

  always_ff @(posedge clk) started <= 1'b1;

  always_comb begin
    for (int i = 0; i < ID_N; i++) id_msbs[i] = dev_ids[i*8+7];
  end

  // R1
  a_r1_reset_values: assert property (@(posedge clk)
    (started && $past(rst)) |-> (thr_codes == {THR_N{8'h7F}} && probe_mode == 8'h40 &&
                                 dev_ids == '0 && stream_byte == 8'h00 && !wr_pulse && !err_pulse));

  // R5
  a_r5_id_msb_zero: assert property (@(posedge clk) disable iff (rst)
    started |-> (id_msbs == '0));

  // R7
  a_r7_change_needs_pulse: assert property (@(posedge clk) disable iff (rst)
    (started && !$past(rst) && !wr_pulse) |->
      ($stable(thr_codes) && $stable(probe_mode) && $stable(dev_ids) && $stable(stream_byte)));

  // R7
  a_r7_pulse_addr_valid: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |-> wr_addr[7]);

  // R8
  a_r8_err_from_bad_byte: assert property (@(posedge clk) disable iff (rst)
    (started && !$past(rst) && err_pulse) |-> ($past(in_valid) && !$past(in_byte[7])));

  // R8
  a_r8_err_excludes_write: assert property (@(posedge clk) disable iff (rst)
    !(err_pulse && wr_pulse));
endmodule

bind cfg_byte_decoder cfg_byte_decoder_chk #(.THR_N(THR_N), .ID_N(ID_N)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_byte     (in_byte),
  .thr_codes   (thr_codes),
  .probe_mode  (probe_mode),
  .dev_ids     (dev_ids),
  .stream_byte (stream_byte),
  .wr_pulse    (wr_pulse),
  .wr_addr     (wr_addr),
  .err_pulse   (err_pulse)
);

// File: tb/cfg_byte_decoder_bench.sv
`timescale 1ns/1ps
module cfg_byte_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic [15:0] thr_codes;
  logic [7:0]  probe_mode;
  logic        diff_56, diff_78;
  logic [23:0] dev_ids;
  logic [7:0]  stream_byte;
  logic        wr_pulse;
  logic [7:0]  wr_addr;
  logic        err_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_thr [2];
  logic [7:0] m_mode;
  logic [7:0] m_id [3];
  logic [7:0] m_strm;

  always #2.5 clk = ~clk;

  cfg_byte_decoder u_cfg_byte_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .thr_codes(thr_codes), .probe_mode(probe_mode), .diff_56(diff_56), .diff_78(diff_78),
    .dev_ids(dev_ids), .stream_byte(stream_byte), .wr_pulse(wr_pulse),
    .wr_addr(wr_addr), .err_pulse(err_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_regs(input string req);
    check({req, " thrA"}, thr_codes[7:0], m_thr[0]);
    check({req, " thrB"}, thr_codes[15:8], m_thr[1]);
    check({req, " mode"}, probe_mode, m_mode);
    check({req, " id0"}, dev_ids[7:0], m_id[0]);
    check({req, " id1"}, dev_ids[15:8], m_id[1]);
    check({req, " id2"}, dev_ids[23:16], m_id[2]);
    check({req, " stream"}, stream_byte, m_strm);
  endtask

  function automatic bit model_write(input logic [7:0] a, input logic [7:0] d);
    case (a)
      8'h89: m_thr[0] = d;
      8'h8A: m_thr[1] = d;
      8'h88: m_mode = d;
      8'h8C: m_id[0] = {1'b0, d[6:0]};
      8'h8E: m_id[1] = {1'b0, d[6:0]};
      8'h8F: m_id[2] = {1'b0, d[6:0]};
      8'h8D: m_strm = d;
      default: return 1'b0;
    endcase
    return 1'b1;
  endfunction

  // one pair, then checks in the cycle after the data edge (R2, R7)
  task automatic cmd(input logic [7:0] a, input logic [7:0] d, input string req);
    bit mapped;
    put(a);
    check({req, " R2 no pulse after address"}, {wr_pulse, err_pulse}, 2'b00);
    put(d);
    mapped = model_write(a, d);
    check({req, " R7 pulse"}, wr_pulse, mapped);
    if (mapped) check({req, " R7 addr"}, wr_addr, a);
    check({req, " err"}, err_pulse, 1'b0);
    check_regs(req);
  endtask

  task automatic t_reset;
    m_thr[0] = 8'h7F; m_thr[1] = 8'h7F; m_mode = 8'h40;
    m_id[0] = 0; m_id[1] = 0; m_id[2] = 0; m_strm = 0;
    idle(3);
    check_regs("R1 in reset");
    check("R1 pulses in reset", {wr_pulse, err_pulse}, 2'b00);
    rst = 1'b0;
    idle(2);
    check_regs("R1 after release");
    check("R1 diff flags", {diff_56, diff_78}, 2'b00);
  endtask

  task automatic t_thresholds;
    cmd(8'h89, 8'h2E, "R3 grpA 1.2V");
    cmd(8'h8A, 8'h6C, "R3 grpB 2.8V");
    cmd(8'h8A, 8'h45, "R3 grpB 1.8V");
    idle(1);
    check("R7 pulse one cycle", wr_pulse, 1'b0);
  endtask

  task automatic t_mode;
    cmd(8'h88, 8'h50, "R4 mode 56");
    check("R4 diff 56 only", {diff_56, diff_78}, 2'b10);
    cmd(8'h88, 8'h48, "R4 mode 78");
    check("R4 diff 78 only", {diff_56, diff_78}, 2'b01);
    cmd(8'h88, 8'h58, "R4 mode both");
    check("R4 diff both", {diff_56, diff_78}, 2'b11);
    cmd(8'h88, 8'h40, "R4 mode normal");
    check("R4 diff none", {diff_56, diff_78}, 2'b00);
  endtask

  task automatic t_ids;
    cmd(8'h8C, 8'hA5, "R5 id0 msb set");
    cmd(8'h8E, 8'h3C, "R5 id1");
    cmd(8'h8F, 8'hFF, "R5 id2 msb set");
    check("R5 id2 value", dev_ids[23:16], 8'h7F);
  endtask

  task automatic t_stream;
    cmd(8'h8D, 8'h01, "R6 stream 1");
    cmd(8'h8D, 8'h05, "R6 stream 2");
    cmd(8'h8D, 8'h01, "R6 stream 3");
    cmd(8'h8D, 8'h02, "R6 stream 4");
    cmd(8'h8D, 8'h06, "R6 stream 5");
  endtask

  task automatic t_gaps;
    put(8'h89);
    idle(3);
    check("R2 gap no pulse", wr_pulse, 1'b0);
    put(8'h39);
    void'(model_write(8'h89, 8'h39));
    check("R2 gap write pulse", wr_pulse, 1'b1);
    check_regs("R2 gap");
  endtask

  task automatic t_bad_addr;
    put(8'h41);
    check("R8 err pulse", err_pulse, 1'b1);
    check("R8 no write", wr_pulse, 1'b0);
    check_regs("R8 nothing written");
    idle(1);
    check("R8 err one cycle", err_pulse, 1'b0);
    cmd(8'h8A, 8'h2E, "R8 stays in address phase");
  endtask

  task automatic t_unmapped;
    put(8'h80);
    put(8'h12);
    check("R9 no pulses", {wr_pulse, err_pulse}, 2'b00);
    check_regs("R9 regs unchanged");
    put(8'h9A);
    put(8'h8C);
    check("R9 msb data consumed", {wr_pulse, err_pulse}, 2'b00);
    check_regs("R9 regs unchanged 2");
    cmd(8'h89, 8'h7F, "R9 parser resynced");
  endtask

  task automatic t_back_to_back;
    put(8'h89); put(8'h45);
    void'(model_write(8'h89, 8'h45));
    check("R10 first pulse", wr_pulse, 1'b1);
    put(8'h8D);
    check("R10 gap in pulse", wr_pulse, 1'b0);
    put(8'h07);
    void'(model_write(8'h8D, 8'h07));
    check("R10 second pulse", wr_pulse, 1'b1);
    check("R10 second addr", wr_addr, 8'h8D);
    put(8'h8E); put(8'h91);
    void'(model_write(8'h8E, 8'h91));
    check("R10 third addr", wr_addr, 8'h8E);
    check_regs("R10 end");
  endtask

  initial begin
    t_reset();
    t_thresholds();
    t_mode();
    t_ids();
    t_stream();
    t_gaps();
    t_bad_addr();
    t_unmapped();
    t_back_to_back();
    idle(2);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule